// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a simple synchronous host port and a 1M x 32 EDO DRAM module. The module is built as two 16-bit halves. Each half has its own row strobe, and each byte lane has its own column strobe. The host presents a single-word request: a 20-bit word address, 32-bit write data, a 4-bit byte enable and a read/write flag. The sequencer accepts the request and plays out one complete random-access cycle on the DRAM pins. The cycle covers row address, row strobe, column address, column strobes and write enable. For a read, the sequencer captures the data word and returns it with a one-cycle valid pulse.

All DRAM minimum times are parameters expressed in clock cycles. With the default values and a 100 MHz clock, every access follows the same fixed 12-cycle schedule, measured from the accepting edge to the next cycle in which ready is high. A separate refresh engine borrows the DRAM pins through a request/grant pair. A grant is given only while the sequencer is idle, and it blocks new host requests while it lasts.

Top module: `edo_seq`

## Requirements
- R1: The row address `req_addr[19:10]` is on `dram_addr` in the cycle before and in the cycle a row strobe falls. The column address `req_addr[9:0]` is driven from T_RAH (1) cycles after the fall until the row strobe rises.
- R2: `dram_ras_n[0]` (data bits 15:0) goes low only if `req_be[0]` or `req_be[1]` is set. `dram_ras_n[1]` (data bits 31:16) goes low only if `req_be[2]` or `req_be[3]` is set.
- R3: `dram_cas_n[i]` strobes byte lane i (data bits 8i+7:8i) and goes low only when `req_be[i]` is set. It falls T_RCD (2) cycles after the row strobe falls and stays low for T_CAS (2) cycles. It is only low while the row strobe of its half is low.
- R4: A row strobe stays low for exactly 6 cycles. Before it falls again it has been high for at least T_RP (4) cycles.
- R5: On a write, `dram_we_n` goes low and `dram_dq_oe` goes high with `req_wdata` on `dram_dq_out`. This starts with the column address, one cycle before the column strobes fall, and lasts until the row strobe rises. On a read, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R6: A read samples `dram_dq_in` at the clock edge that ends the 6th row-strobe-low cycle. The word is returned on `rd_data` with `rd_valid` high for one cycle, in the cycle after the row strobe rises. Byte lanes whose enable is clear read as zero.
- R7: `req_ready` falls after the accepting edge and rises again only after the precharge has finished. It returns 12 cycles after the accepting cycle.
- R8: A request with `req_be` equal to 0 drives no strobe and keeps `req_ready` high. A read of this kind returns `rd_valid` in the next cycle with `rd_data` equal to 0.
- R9: `ref_gnt` is high only while `ref_req` is high and the sequencer is idle, with all strobes high. While `ref_req` is high, `req_ready` is low and no request is accepted.
- R10: During and after reset, all strobes and `dram_we_n` are high, `dram_dq_oe` is low, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in bits 19:10, column in bits 9:0 |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh engine asks for the DRAM pins |
| ref_gnt | output | 1 | Pins handed to the refresh engine |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, index 0 low half, index 1 high half |
| dram_cas_n | output | 4 | Column strobes, one per byte lane |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Output enable for dram_dq_out |
| dram_dq_in | input | 32 | Data returned by the DRAM |

## Verification
The embedded checks assume three things about the inputs. First, the host holds a request steady only in cycles where it is presented with `req_valid`. Second, the refresh engine drives the DRAM only while `ref_gnt` is high. Third, the timing parameters satisfy 1 <= T_RAH <= T_RCD. The bench drives every input half a cycle away from the active edge. It presents a request only when `req_ready` is seen high, and raises or drops `ref_req` at those same half-cycle points. It plays the DRAM side with a behavioural byte-lane memory that latches row and column on the falling strobes and holds the read word until the row strobe rises, as an extended-data-out part does.

// File: rtl/edo_seq_pkg.sv
// Shared types for the EDO DRAM sequencer.
// Assumes: one phase record per cycle, produced by the controller and
// consumed by the pin generator.
package edo_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECHG
    } seq_state_t;

    // Registered per-cycle phase of the DRAM access.
    typedef struct packed {
        logic ras_on;   // row strobe active
        logic col_on;   // column address on the bus
        logic cas_on;   // column strobes active
        logic wr_on;    // write enable and data drive active
    } phase_t;

endpackage

// File: rtl/edo_seq_ctrl.sv
// Access controller: steps idle -> row setup -> row active -> precharge
// and produces registered phase flags for the pin generator.
// Assumes 1 <= T_RAH <= T_RCD and T_RCD + T_CAS <= active length.
module edo_seq_ctrl
    import edo_seq_pkg::*;
#(
    parameter int T_RAH    = 1,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_RAS    = 6,
    parameter int T_RP     = 4,
    parameter int T_SAMPLE = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   be_any,
    input  logic   ref_req,
    output logic   req_ready,
    output logic   ref_gnt,
    output logic   accept,
    output logic   zero_rd,
    output logic   sample_stb,
    output phase_t phase
);
    localparam int T_ACT0  = (T_RAS > T_SAMPLE) ? T_RAS : T_SAMPLE;
    localparam int T_ACT   = (T_ACT0 > T_RCD + T_CAS) ? T_ACT0 : T_RCD + T_CAS;
    localparam int CNT_W   = $clog2(T_ACT + T_RP + 1);
    localparam int RUN_W   = $clog2(T_ACT + T_RP + 2);
    localparam logic [CNT_W-1:0] ONE_V     = CNT_W'(1);
    localparam logic [CNT_W-1:0] ACT_LAST  = CNT_W'(T_ACT - 1);
    localparam logic [CNT_W-1:0] RP_LAST   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RAH_V     = CNT_W'(T_RAH);
    localparam logic [CNT_W-1:0] RCD_V     = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] CAS_END_V = CNT_W'(T_RCD + T_CAS);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(T_ACT + T_RP + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             is_wr;

    // Host/refresh handshake decode from the current state.
    always_comb begin
        req_ready  = (state == ST_IDLE) && !ref_req;
        ref_gnt    = (state == ST_IDLE) && ref_req;
        accept     = req_valid && req_ready;
        zero_rd    = accept && !be_any && !req_write;
        sample_stb = (state == ST_ACTIVE) && (cnt == ACT_LAST) && !is_wr;
        cnt_inc    = cnt + ONE_V;
    end

    // Sequence state, cycle counter and registered phase flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
            phase <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && be_any) begin
                        state <= ST_SETUP;
                        is_wr <= req_write;
                    end
                end
                ST_SETUP: begin
                    state        <= ST_ACTIVE;
                    cnt          <= '0;
                    phase.ras_on <= 1'b1;
                    phase.col_on <= 1'b0;
                    phase.cas_on <= 1'b0;
                    phase.wr_on  <= 1'b0;
                end
                ST_ACTIVE: begin
                    if (cnt == ACT_LAST) begin
                        state <= ST_PRECHG;
                        cnt   <= '0;
                        phase <= '0;
                    end else begin
                        cnt          <= cnt_inc;
                        phase.col_on <= (cnt_inc >= RAH_V);
                        phase.cas_on <= (cnt_inc >= RCD_V) && (cnt_inc < CAS_END_V);
                        phase.wr_on  <= is_wr && (cnt_inc >= RAH_V);
                    end
                end
                ST_PRECHG: begin
                    if (cnt == RP_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: length of the current row-strobe low and high runs.
    logic [RUN_W-1:0] lo_run;
    logic [RUN_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= RUN_MAX;
        end else if (phase.ras_on) begin
            lo_run <= lo_run + RUN_W'(1);
            hi_run <= '0;
        end else begin
            lo_run <= '0;
            hi_run <= (hi_run == RUN_MAX) ? RUN_MAX : hi_run + RUN_W'(1);
        end
    end

    assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase.ras_on) |-> (lo_run == RUN_W'(T_ACT)));
    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase.ras_on) |-> (hi_run >= RUN_W'(T_RP)));
    assert_busy_in_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase.ras_on |-> !req_ready);
    assert_cas_after_col_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase.cas_on |-> phase.col_on);

endmodule

// File: rtl/edo_seq_pins.sv
// Pin generator: latches the accepted request and gates the phase flags
// per half and per byte lane onto the DRAM pins.
// Assumes the phase flags are registered, so outputs change once per edge.
module edo_seq_pins
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int HALVES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [2*ROW_W-1:0]        req_addr,
    input  logic [LANE_W*LANES-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_be,
    input  phase_t                    phase,
    output logic [ROW_W-1:0]          dram_addr,
    output logic [HALVES-1:0]         dram_ras_n,
    output logic [LANES-1:0]          dram_cas_n,
    output logic                      dram_we_n,
    output logic [LANE_W*LANES-1:0]   dram_dq_out,
    output logic                      dram_dq_oe,
    output logic [LANES-1:0]          be_lat
);
    localparam int LPH = LANES / HALVES;

    logic [2*ROW_W-1:0]      addr_lat;
    logic [LANE_W*LANES-1:0] wdata_lat;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat  <= '0;
            wdata_lat <= '0;
            be_lat    <= '0;
        end else if (accept) begin
            addr_lat  <= req_addr;
            wdata_lat <= req_wdata;
            be_lat    <= req_be;
        end
    end

    // Row/column multiplexing and write drive.
    always_comb begin
        dram_addr   = phase.col_on ? addr_lat[ROW_W-1:0] : addr_lat[2*ROW_W-1:ROW_W];
        dram_we_n   = !phase.wr_on;
        dram_dq_oe  = phase.wr_on;
        dram_dq_out = wdata_lat;
    end

    // One row strobe per half, active when any lane of the half is enabled.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign dram_ras_n[h] = !(phase.ras_on && (|be_lat[h*LPH +: LPH]));
    end

    // One column strobe per byte lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dram_cas_n[l] = !(phase.cas_on && be_lat[l]);

        assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !dram_cas_n[l] |-> !dram_ras_n[l / LPH]);
        assert_early_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(dram_cas_n[l]) && !dram_we_n) |-> $stable(dram_we_n));
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_row_chk
        assert_row_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dram_ras_n[h]) |-> $stable(dram_addr));
    end

endmodule

// File: rtl/edo_seq_capture.sv
// Read capture: samples the DRAM data word at the strobe from the
// controller, zeroes disabled lanes and pulses the valid flag.
// Assumes the DRAM keeps its output until the row strobe rises.
module edo_seq_capture #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_stb,
    input  logic                    zero_rd,
    input  logic [LANES-1:0]        be_lat,
    input  logic [LANE_W*LANES-1:0] dq_in,
    output logic                    rd_valid,
    output logic [LANE_W*LANES-1:0] rd_data
);
    logic [LANE_W*LANES-1:0] masked;

    // Lane masking by the latched byte enables.
    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign masked[l*LANE_W +: LANE_W] = be_lat[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
    end

    // Register the returned word and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sample_stb || zero_rd;
            if (sample_stb) begin
                rd_data <= masked;
            end else if (zero_rd) begin
                rd_data <= '0;
            end
        end
    end

    assert_single_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && zero_rd));

endmodule

// File: rtl/edo_seq.sv
// Top of the EDO DRAM sequencer: host port in, DRAM pins out, refresh
// engine handshake. Assumes the refresh engine owns the pins only while
// ref_gnt is high.
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int LANE_W   = 8,
    parameter int LANES    = 4,
    parameter int HALVES   = 2,
    parameter int T_RAH    = 1,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_RAS    = 6,
    parameter int T_RP     = 4,
    parameter int T_SAMPLE = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [2*ROW_W-1:0]      req_addr,
    input  logic [LANE_W*LANES-1:0] req_wdata,
    input  logic [LANES-1:0]        req_be,
    output logic                    rd_valid,
    output logic [LANE_W*LANES-1:0] rd_data,
    input  logic                    ref_req,
    output logic                    ref_gnt,
    output logic [ROW_W-1:0]        dram_addr,
    output logic [HALVES-1:0]       dram_ras_n,
    output logic [LANES-1:0]        dram_cas_n,
    output logic                    dram_we_n,
    output logic [LANE_W*LANES-1:0] dram_dq_out,
    output logic                    dram_dq_oe,
    input  logic [LANE_W*LANES-1:0] dram_dq_in
);
    phase_t           phase;
    logic             accept;
    logic             zero_rd;
    logic             sample_stb;
    logic             be_any;
    logic [LANES-1:0] be_lat;

    assign be_any = |req_be;

    edo_seq_ctrl #(
        .T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_SAMPLE(T_SAMPLE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .be_any(be_any), .ref_req(ref_req), .req_ready(req_ready),
        .ref_gnt(ref_gnt), .accept(accept), .zero_rd(zero_rd),
        .sample_stb(sample_stb), .phase(phase)
    );

    edo_seq_pins #(
        .ROW_W(ROW_W), .LANE_W(LANE_W), .LANES(LANES), .HALVES(HALVES)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .phase(phase),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .be_lat(be_lat)
    );

    edo_seq_capture #(
        .LANE_W(LANE_W), .LANES(LANES)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .zero_rd(zero_rd),
        .be_lat(be_lat), .dq_in(dram_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assert_gnt_pins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> ((&dram_ras_n) && (&dram_cas_n) && dram_we_n && !dram_dq_oe));
    assert_gnt_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> !req_ready);

endmodule

// File: tb/edo_seq_test.sv
// Bench for edo_seq: directed corner cases plus seeded random requests,
// a behavioural EDO memory on the DRAM side and a per-cycle pin schedule.
module edo_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [19:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_be;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        ref_req, ref_gnt;
    logic [9:0]  dram_addr;
    logic [1:0]  dram_ras_n;
    logic [3:0]  dram_cas_n;
    logic        dram_we_n;
    logic [31:0] dram_dq_out;
    logic        dram_dq_oe;
    logic [31:0] dram_dq_in;

    always #5 clk = ~clk;

    edo_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(logic [19:0] a);
        return {a[11:0], a} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    // Reference memory kept from the requirements, and the DRAM model memory.
    logic [31:0] gold [int];
    logic [31:0] dmem [int];

    function automatic logic [31:0] gold_rd(logic [19:0] a);
        return gold.exists(int'(a)) ? gold[int'(a)] : seed_word(a);
    endfunction

    function automatic logic [31:0] dmem_rd(logic [19:0] a);
        return dmem.exists(int'(a)) ? dmem[int'(a)] : seed_word(a);
    endfunction

    // Behavioural EDO DRAM: rows latched on row strobe fall, columns on
    // column strobe fall, read word held until the row strobe rises.
    logic [1:0]  ras_q = 2'b11;
    logic [3:0]  cas_q = 4'hF;
    logic [9:0]  mrow [2];
    logic [19:0] mkey [2];
    bit          mcol_ok [2];
    initial dram_dq_in = 32'hBAD0_BAD0;

    always @(negedge clk) begin
        logic [31:0] w;
        for (int h = 0; h < 2; h++) begin
            if (ras_q[h] && !dram_ras_n[h]) mrow[h] = dram_addr;
            if (dram_ras_n[h]) mcol_ok[h] = 0;
        end
        for (int b = 0; b < 4; b++) begin
            if (cas_q[b] && !dram_cas_n[b]) begin
                mkey[b/2]    = {mrow[b/2], dram_addr};
                mcol_ok[b/2] = 1;
                if (!dram_we_n) begin
                    w = dmem_rd(mkey[b/2]);
                    w[8*b +: 8] = dram_dq_out[8*b +: 8];
                    dmem[int'(mkey[b/2])] = w;
                end
            end
        end
        for (int h = 0; h < 2; h++) begin
            if (mcol_ok[h]) begin
                w = dmem_rd(mkey[h]);
                dram_dq_in[16*h +: 16] = w[16*h +: 16];
            end else begin
                dram_dq_in[16*h +: 16] = 16'hBAD0;
            end
        end
        ras_q = dram_ras_n;
        cas_q = dram_cas_n;
    end

    // One access; pins are checked in every cycle k after the accepting cycle.
    task automatic do_req(bit wr, logic [19:0] a, logic [31:0] d, logic [3:0] be, int ref_at);
        logic [31:0] exp_rd, w;
        logic [1:0]  e_ras;
        logic [3:0]  e_cas;
        bit          e_we;
        while (!req_ready) @(negedge clk);
        exp_rd = gold_rd(a) & lane_mask(be);
        if (wr) begin
            w = gold_rd(a);
            w = (w & ~lane_mask(be)) | (d & lane_mask(be));
            gold[int'(a)] = w;
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_be = ~be;
        if (be == 4'h0) begin
            chk(dram_ras_n == 2'b11 && dram_cas_n == 4'hF && dram_we_n, "R8", "zero-enable pins",
                {dram_ras_n, dram_cas_n, dram_we_n}, 7'h7F);
            chk(req_ready == 1'b1, "R8", "zero-enable ready", req_ready, 1);
            chk(rd_valid == !wr, "R8", "zero-enable rd_valid", rd_valid, !wr);
            if (!wr) chk(rd_data == 32'h0, "R8", "zero-enable rd_data", rd_data, 0);
            @(negedge clk);
            chk(dram_ras_n == 2'b11, "R8", "zero-enable no row strobe later", dram_ras_n, 2'b11);
            return;
        end
        for (int k = 1; k <= 12; k++) begin
            if (k > 1) @(negedge clk);
            e_ras = (k >= 2 && k <= 7) ? ~{|be[3:2], |be[1:0]} : 2'b11;
            e_cas = (k >= 4 && k <= 5) ? ~be : 4'hF;
            e_we  = !(wr && k >= 3 && k <= 7);
            chk(dram_ras_n == e_ras, "R2", $sformatf("row strobes k=%0d", k), dram_ras_n, e_ras);
            chk(dram_cas_n == e_cas, "R3", $sformatf("column strobes k=%0d", k), dram_cas_n, e_cas);
            chk(dram_we_n == e_we && dram_dq_oe == !e_we, "R5", $sformatf("we/oe k=%0d", k),
                {dram_we_n, dram_dq_oe}, {e_we, !e_we});
            if (!e_we) chk(dram_dq_out == d, "R5", "write data", dram_dq_out, d);
            if (k <= 2) chk(dram_addr == a[19:10], "R1", $sformatf("row addr k=%0d", k), dram_addr, a[19:10]);
            else if (k <= 7) chk(dram_addr == a[9:0], "R1", $sformatf("col addr k=%0d", k), dram_addr, a[9:0]);
            chk(req_ready == (k == 12 && !ref_req), "R7", $sformatf("ready k=%0d", k),
                req_ready, (k == 12 && !ref_req));
            chk(ref_gnt == (k == 12 && ref_req), "R9", $sformatf("grant k=%0d", k),
                ref_gnt, (k == 12 && ref_req));
            chk(rd_valid == (!wr && k == 8), "R6", $sformatf("rd_valid k=%0d", k), rd_valid, (!wr && k == 8));
            if (!wr && k == 8) chk(rd_data == exp_rd, "R6", "read data", rd_data, exp_rd);
            if (k == ref_at) ref_req = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_be = '0; ref_req = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(dram_ras_n == 2'b11 && dram_cas_n == 4'hF && dram_we_n && !dram_dq_oe, "R10",
            "reset pins", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 8'hFE);
        chk(!rd_valid && req_ready, "R10", "reset rd_valid/ready", {rd_valid, req_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && dram_ras_n == 2'b11, "R10", "after reset", {req_ready, dram_ras_n}, 3'b111);

        // Directed: full word write and read back (R1..R7)
        do_req(1, 20'hABCDE, 32'h1234_5678, 4'hF, 0);
        do_req(0, 20'hABCDE, 32'h0, 4'hF, 0);
        // Single lane in the low half: only row strobe 0, column strobe 1 (R2, R3)
        do_req(1, 20'h00301, 32'hCAFE_F00D, 4'b0010, 0);
        do_req(0, 20'h00301, 32'h0, 4'hF, 0);
        // Upper half only read, lower lanes zero (R6)
        do_req(0, 20'hABCDE, 32'h0, 4'b1100, 0);
        // Zero-enable write and read (R8)
        do_req(1, 20'h00301, 32'hFFFF_FFFF, 4'h0, 0);
        do_req(0, 20'h00301, 32'h0, 4'h0, 0);
        do_req(0, 20'h00301, 32'h0, 4'hF, 0);
        // Refresh asked mid-access: grant waits for precharge (R9)
        do_req(0, 20'hFFFFF, 32'h0, 4'b0101, 5);
        chk(ref_gnt && !req_ready, "R9", "grant held", {ref_gnt, req_ready}, 2'b10);
        // Host request while refresh owns the pins is not accepted (R9)
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00301; req_wdata = 32'h0; req_be = 4'hF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dram_ras_n == 2'b11 && ref_gnt && !req_ready, "R9", "blocked while granted",
                {dram_ras_n, ref_gnt, req_ready}, 4'b1110);
        end
        req_valid = 1'b0;
        ref_req = 1'b0;
        @(negedge clk);
        chk(req_ready && !ref_gnt, "R9", "release grant", {req_ready, ref_gnt}, 2'b10);
        do_req(0, 20'h00301, 32'h0, 4'hF, 0);

        // Random mix on a small address pool so reads meet earlier writes.
        for (int n = 0; n < 70; n++) begin
            logic [19:0] a;
            logic [3:0]  be;
            a  = {8'h5A, 2'($urandom_range(0, 3)), 7'h11, 3'($urandom_range(0, 7))};
            be = 4'($urandom_range(0, 15));
            do_req(1'($urandom_range(0, 1)), a, $urandom, be, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule